// File: doc/BRIEF.md
# Paged SRAM Write-Protect Guard

This block sits between a system bus and a 32 KB on-chip SRAM that is split into 32 pages of 1 KB. It keeps a 32-bit protect map, one bit per page, that software can only ever set; the bits fall back to zero only on a system reset. Every bus write is checked against the protect bit of the page that its address falls in. A write to a protected page never reaches the memory and is answered with a bus error in the same cycle. Writes to open pages and all reads go through unchanged.

A hardware erase engine shares the memory write port. Erase writes take priority over the bus, bypass protection entirely, and hold the bus handshake low while they run, so a bus access waits until the erase is over.

Top module: `wp_guard`

## Requirements
- R1: After a synchronous active-low reset the protect map `prot_map` reads all zeros.
- R2: A register write (`cfg_we` high for one cycle) ORs `cfg_wdata` into the protect map, and the new value is visible on `prot_map` from the next cycle on.
- R3: A zero bit in `cfg_wdata` never clears a protect bit; only reset clears them.
- R4: The page of a bus access is byte-address bits [14:10], and bit y of `prot_map` guards page y (byte addresses y*1024 to y*1024+1023).
- R5: A bus write (`bus_req` and `bus_we` high, `bus_ready` high) to a protected page keeps `mem_we` low and drives `bus_err` high in that same cycle.
- R6: A bus write to an unprotected page drives `mem_we` high with `mem_addr` equal to `bus_addr` and `bus_err` low.
- R7: A bus read (`bus_req` high, `bus_we` low) never raises `bus_err` or `mem_we`, whether its page is protected or not.
- R8: While `erase_we` is high, `mem_we` is high with `mem_addr` equal to `erase_addr` even on protected pages, `bus_ready` is low and `bus_err` is low.
- R9: `bus_err` is high only in a cycle with an accepted bus write; an idle bus gives no error and no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Protect-map register write strobe |
| cfg_wdata | input | 32 | Bits to set in the protect map |
| prot_map | output | 32 | Current protect map |
| bus_req | input | 1 | Bus access valid |
| bus_we | input | 1 | Bus access is a write |
| bus_addr | input | 15 | Bus byte address within the SRAM |
| bus_ready | output | 1 | Bus access accepted this cycle |
| bus_err | output | 1 | Error response for a blocked write |
| erase_we | input | 1 | Erase engine write strobe |
| erase_addr | input | 15 | Erase engine byte address |
| mem_we | output | 1 | Gated SRAM write enable |
| mem_addr | output | 15 | SRAM byte address |

## Verification
The guard is driven with writes to a single protected page surrounded by open neighbours, including the last byte of the page below and the first word of the page above, which separates a correct bit [14:10] page decode from one shifted by a bit. A walk over all 32 pages with a sparse map catches a wrong bit-to-page mapping, and reads to protected pages tell a write-only check from one that blocks every access. Register writes of zero after bits are set separate set-only behaviour from a plain load, and an erase overlapping a bus write to a protected page shows that erase bypasses the map and stalls the bus instead of erroring.

// File: rtl/wp_guard_pkg.sv
// Shared parameters and types for the paged write-protect guard.
package wp_guard_pkg;
    localparam int unsigned DEF_ADDR_W    = 15;  // 32 KB byte address
    localparam int unsigned DEF_PAGE_LSB  = 10;  // 1 KB pages
    localparam int unsigned DEF_NUM_PAGES = 32;

    // Which agent owns the memory write port in a cycle.
    typedef enum logic [1:0] {
        SRC_IDLE  = 2'd0,
        SRC_BUS   = 2'd1,
        SRC_ERASE = 2'd2
    } wp_src_e;
endpackage

// File: rtl/wp_prot_reg.sv
// Set-only protect map. Each register write ORs its data into the map;
// nothing but a synchronous reset clears a bit.
// Assumes: one write strobe, data already aligned to page bit order.
module wp_prot_reg #(
    parameter int unsigned NUM_PAGES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_we,
    input  logic [NUM_PAGES-1:0] set_bits,
    output logic [NUM_PAGES-1:0] prot_q
);
    // Accumulate set requests; reset is the only way back to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot_q <= '0;
        end else if (set_we) begin
            prot_q <= prot_q | set_bits;
        end
    end

    // R3: no protect bit drops while out of reset.
    a_r3_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((prot_q & $past(prot_q)) == $past(prot_q)));

    // R2: every bit written as one is held the cycle after.
    a_r2_set_visible: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((prot_q & $past(set_bits)) == $past(set_bits)));
endmodule

// File: rtl/wp_page_check.sv
// Page decoder and protect lookup. Extracts the page index from the byte
// address, expands it to a one-hot page select and reports whether the
// selected page is protected.
// Assumes: NUM_PAGES is a power of two and fits above PAGE_LSB in ADDR_W.
module wp_page_check #(
    parameter int unsigned ADDR_W    = 15,
    parameter int unsigned PAGE_LSB  = 10,
    parameter int unsigned NUM_PAGES = 32
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic [NUM_PAGES-1:0] prot,
    output logic                 hit
);
    localparam int unsigned PAGE_W = $clog2(NUM_PAGES);

    logic [PAGE_W-1:0]    page_idx;
    logic [NUM_PAGES-1:0] page_sel;

    // Page index is the address field directly above the in-page offset.
    always_comb begin
        page_idx = addr[PAGE_LSB +: PAGE_W];
    end

    // One comparator per page builds the select vector.
    for (genvar p = 0; p < NUM_PAGES; p++) begin : g_dec
        assign page_sel[p] = (page_idx == PAGE_W'(p));
    end

    // Protected when the selected page has its bit set.
    always_comb begin
        hit = |(page_sel & prot);
    end

    // R4: the decoder selects exactly one page for any address.
    always_comb begin
        a_r4_one_page: assert ($countones(page_sel) == 1);
    end
endmodule

// File: rtl/wp_guard.sv
// Top of the paged write-protect guard. Arbitrates the SRAM write port
// between the erase engine (priority, ignores protection) and the bus,
// blocks bus writes to protected pages and flags them with a one-cycle
// error that coincides with the accepted handshake.
// Assumes: erase_we is held by the erase engine for each word it clears;
// the bus holds its request while bus_ready is low.
module wp_guard
    import wp_guard_pkg::*;
#(
    parameter int unsigned ADDR_W    = DEF_ADDR_W,
    parameter int unsigned PAGE_LSB  = DEF_PAGE_LSB,
    parameter int unsigned NUM_PAGES = DEF_NUM_PAGES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [NUM_PAGES-1:0] cfg_wdata,
    output logic [NUM_PAGES-1:0] prot_map,
    input  logic                 bus_req,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    output logic                 bus_ready,
    output logic                 bus_err,
    input  logic                 erase_we,
    input  logic [ADDR_W-1:0]    erase_addr,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr
);
    logic    page_prot;
    wp_src_e src;

    wp_prot_reg #(
        .NUM_PAGES (NUM_PAGES)
    ) i_prot_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_we   (cfg_we),
        .set_bits (cfg_wdata),
        .prot_q   (prot_map)
    );

    wp_page_check #(
        .ADDR_W    (ADDR_W),
        .PAGE_LSB  (PAGE_LSB),
        .NUM_PAGES (NUM_PAGES)
    ) i_page_check (
        .addr (bus_addr),
        .prot (prot_map),
        .hit  (page_prot)
    );

    // Pick the owner of the write port: erase first, then bus writes.
    always_comb begin
        if (erase_we) begin
            src = SRC_ERASE;
        end else if (bus_req && bus_we) begin
            src = SRC_BUS;
        end else begin
            src = SRC_IDLE;
        end
    end

    // Bus is stalled for the whole erase.
    always_comb begin
        bus_ready = !erase_we;
    end

    // Gate the write enable and raise the error on blocked bus writes.
    always_comb begin
        mem_we  = 1'b0;
        bus_err = 1'b0;
        unique case (src)
            SRC_ERASE: mem_we  = 1'b1;
            SRC_BUS:   begin
                mem_we  = !page_prot;
                bus_err = page_prot;
            end
            default:   ;
        endcase
    end

    // Address follows the owner; reads use the bus address.
    always_comb begin
        mem_addr = erase_we ? erase_addr : bus_addr;
    end

    // R5: an error response never comes with a memory write.
    a_r5_block: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> !mem_we);

    // R7: reads see no error and cause no write.
    a_r7_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && !erase_we) |-> (!bus_err && !mem_we));

    // R8: erase writes regardless of protection and holds the bus.
    a_r8_erase_wins: assert property (@(posedge clk) disable iff (!rst_n)
        erase_we |-> (mem_we && !bus_err && !bus_ready));

    // R9: errors only answer accepted bus writes.
    a_r9_err_source: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (bus_req && bus_we && bus_ready));
endmodule

// File: tb/test_wp_guard.sv
module test_wp_guard;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic        we;
        logic        err;
        logic        rdy;
        logic [14:0] addr;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] prot_map;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [14:0] bus_addr = '0;
    logic        bus_ready;
    logic        bus_err;
    logic        erase_we = 1'b0;
    logic [14:0] erase_addr = '0;
    logic        mem_we;
    logic [14:0] mem_addr;

    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;
    logic [31:0] model = '0;
    exp_t sb[$];

    wp_guard i_wp_guard (
        .clk (clk), .rst_n (rst_n),
        .cfg_we (cfg_we), .cfg_wdata (cfg_wdata), .prot_map (prot_map),
        .bus_req (bus_req), .bus_we (bus_we), .bus_addr (bus_addr),
        .bus_ready (bus_ready), .bus_err (bus_err),
        .erase_we (erase_we), .erase_addr (erase_addr),
        .mem_we (mem_we), .mem_addr (mem_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Monitor: compare outputs against the queued item a quarter period after the drive edge.
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (mem_we !== e.we || bus_err !== e.err || bus_ready !== e.rdy ||
                    (e.we && mem_addr !== e.addr)) begin
                    failures++;
                    $display("FAIL %s: we/err/rdy/addr=%b/%b/%b/%h expected %b/%b/%b/%h",
                             e.tag, mem_we, bus_err, bus_ready, mem_addr,
                             e.we, e.err, e.rdy, e.addr);
                end
            end
        end
    end

    // Driver: one bus/erase cycle, expected values from the bench's own model.
    task automatic access(input logic req, input logic we, input logic [14:0] a,
                          input logic er, input logic [14:0] ea, input string tag);
        exp_t e;
        logic prot;
        @(negedge clk);
        bus_req = req; bus_we = we; bus_addr = a;
        erase_we = er; erase_addr = ea;
        prot = model[a[14:10]];
        e.tag = tag;
        e.rdy = !er;
        if (er) begin
            e.we = 1'b1; e.err = 1'b0; e.addr = ea;
        end else if (req && we) begin
            e.we = !prot; e.err = prot; e.addr = a;
        end else begin
            e.we = 1'b0; e.err = 1'b0; e.addr = a;
        end
        sb.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0; erase_we = 1'b0; cfg_we = 1'b0;
    endtask

    task automatic cfg_write(input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b0; erase_we = 1'b0;
        cfg_we = 1'b1; cfg_wdata = d;
        model = model | d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic check_map(input string tag);
        @(negedge clk);
        #(CLK_PERIOD/4);
        checks++;
        if (prot_map !== model) begin
            failures++;
            $display("FAIL %s: prot_map=%h expected %h", tag, prot_map, model);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_map("R1 reset map");
        access(1, 1, 15'h1400, 0, 0, "R6 open page write");

        cfg_write(32'h8000_0020);
        check_map("R2 set pages 5 and 31");
        access(1, 1, 15'h1404, 0, 0, "R5 write to page 5 blocked");
        access(1, 1, 15'h13FF, 0, 0, "R4 last byte of page 4 open");
        access(1, 1, 15'h1800, 0, 0, "R4 first byte of page 6 open");
        access(1, 1, 15'h7C00, 0, 0, "R4 page 31 blocked");
        access(1, 1, 15'h7BFC, 0, 0, "R4 page 30 open");
        access(1, 0, 15'h1404, 0, 0, "R7 read of protected page");
        access(1, 0, 15'h0010, 0, 0, "R7 read of open page");
        idle();

        cfg_write(32'h0000_0000);
        check_map("R3 zero write keeps bits");
        access(1, 1, 15'h17FC, 0, 0, "R3 page 5 still blocked");
        cfg_write(32'h0000_0001);
        check_map("R2 add page 0");
        access(1, 1, 15'h0000, 0, 0, "R5 page 0 blocked");

        access(1, 1, 15'h1404, 1, 15'h1408, "R8 erase over protected page");
        access(0, 0, 15'h0000, 1, 15'h7C04, "R8 erase page 31");
        access(0, 1, 15'h1404, 0, 0, "R9 idle bus no error");
        idle();

        cfg_write(32'h0A50_0C02);
        check_map("R2 sparse map");
        for (int p = 0; p < 32; p++) begin
            access(1, 1, 15'(p * 1024 + 4 * p), 0, 0, "R4 page walk");
        end
        idle();

        @(negedge clk);
        rst_n = 1'b0;
        model = '0;
        @(negedge clk);
        rst_n = 1'b1;
        check_map("R1 map cleared by reset");
        access(1, 1, 15'h7C00, 0, 0, "R1 page 31 open after reset");
        idle();
        repeat (2) @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule